// File: doc/BRIEF.md
# Indirect Bank Register File

This block is the configuration register file of a cartridge memory controller, sitting on the CPU bus. Software never addresses a configuration register directly. It first writes a 4-bit command number into a command port in the 0x8000–0x9FFF region. It then writes the value through a data port in the 0xA000–0xBFFF region. The stored command chooses which register takes that value. Only address bits [15:13] take part in decoding, so any address inside a region reaches its port.

The registers are:
- eight 1 KiB pattern-bank numbers;
- three 8 KiB program-bank numbers, for the windows at 0x8000, 0xA000 and 0xC000;
- a work-RAM control byte for the 0x6000 window;
- a two-bit nametable mirroring code;
- a 16-bit interrupt timer.

The timer counter is loaded one byte at a time through the same indirect path. It counts down once for each CPU clock-enable pulse while running. When it wraps from zero and is armed, it raises an active-high IRQ line. Any write to the timer control register drops that line.

The IRQ line is driven by a two-state machine. In `LINE_IDLE` the line is low. The transition "armed wrap" (a counted pulse finds the counter at zero while the arm bit is set) moves it to `LINE_PENDING`, where the line is high. The transition "acknowledge" (a data-port write while the command is 13) returns it to `LINE_IDLE`. Address translation, the CPU and the picture unit lie outside this block.

Top module: `cart_bank_regfile`

## Requirements
- R1: After reset, or while rst_n is low, the outputs are as follows. Every pattern-bank and program-bank output is 0. Work-RAM enable and RAM select are 0. The mirroring code is 0 (vertical). IRQ is low. Internally the stored command is 0, the counter is 0 and the timer is stopped and disarmed.
- R2: A write with cpu_addr[15:13] = 3'b100 stores cpu_wdata[3:0] as the command and leaves every output unchanged.
- R3: A write with cpu_addr[15:13] = 3'b101 goes to the register picked by the stored command. A write with any other value of cpu_addr[15:13] changes no register.
- R4: Commands 0 to 7 load pattern-bank register n, which drives pat_banks[8n+7:8n], with all 8 data bits.
- R5: Command 8 loads work-RAM control. Data bit 7 drives wram_enable, bit 6 drives wram_is_ram, and bits [5:0] drive wram_bank.
- R6: Commands 9, 10 and 11 load the program banks for 0x8000, 0xA000 and 0xC000. These drive prg_banks[5:0], [11:6] and [17:12]. Only the low 6 data bits are kept.
- R7: Command 12 sets mirror_mode from data bits [1:0]: 0 vertical, 1 horizontal, 2 single-screen A, 3 single-screen B. The upper data bits are ignored.
- R8: Command 14 replaces the counter's low byte and command 15 its high byte; the other byte is kept.
- R9: Command 13 stores the timer control byte: bit 7 = run, bit 0 = arm. While run is set, each cycle with cpu_ce high decrements the counter by one. There is no decrement without cpu_ce, with run clear, or in a cycle that carries a data-port write with command 13, 14 or 15.
- R10: A counted pulse that finds the counter at 0x0000 reloads it as 0xFFFF. If arm is set, irq is high from the next clock edge. If arm is clear, irq stays low.
- R11: Once high, irq stays high until a data-port write with command 13, after which it is low from the next edge.
- R12: Register writes are sampled on a rising clock edge with cpu_wr high, and the new value is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per bus write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_ce | input | 1 | One-cycle pulse per CPU clock, drives the timer |
| pat_banks | output | 64 | Eight 8-bit pattern-bank numbers, bank n at [8n+7:8n] |
| prg_banks | output | 18 | Three 6-bit program-bank numbers for 0x8000, 0xA000, 0xC000 |
| wram_bank | output | 6 | Program bank for the 0x6000 window when RAM is not selected |
| wram_is_ram | output | 1 | 0x6000 window maps work RAM |
| wram_enable | output | 1 | Work RAM enabled |
| mirror_mode | output | 2 | Mirroring code |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench counts clock-enable pulses to the IRQ edge. It expects the line to rise after exactly the loaded value plus one pulse. An off-by-one tick would show up as a line that rises one pulse early or one pulse late.

It reloads only the high byte over an earlier full load. A design that cleared the other byte would then fire at the wrong pulse.

It sends a clock-enable pulse in the same cycle as a control write. A design that let that pulse count would fire one pulse too soon.

It also checks three more cases:
- A wrap with arm clear must leave the line low.
- The command nibble must be taken from the low four bits only.
- Writes outside the two ports must not disturb a bank register.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int ADDR_BITS  = 16;
    localparam int BYTE_BITS  = 8;
    localparam int SEL_BITS   = 4;
    localparam int N_PATTERN  = 8;
    localparam int N_PROGRAM  = 3;
    localparam int PROG_BITS  = 6;
    localparam int TIMER_BITS = 16;

    typedef enum logic [1:0] {
        MIR_VERTICAL   = 2'd0,
        MIR_HORIZONTAL = 2'd1,
        MIR_SINGLE_A   = 2'd2,
        MIR_SINGLE_B   = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CMD  = 2'd1,
        RGN_DATA = 2'd2
    } bus_region_e;

    typedef enum logic {
        LINE_IDLE    = 1'b0,
        LINE_PENDING = 1'b1
    } irq_line_e;

endpackage

// File: rtl/cart_bus_decode.sv
module cart_bus_decode
    import cart_bank_pkg::*;
#(
    parameter int ADDR_W = ADDR_BITS,
    parameter int CMD_W  = SEL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [2:0]        region_bits,
    input  logic [CMD_W-1:0]  sel_nibble,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              data_wr
);

    bus_region_e region;

    always_comb begin
        unique case (region_bits)
            3'b100:  region = RGN_CMD;
            3'b101:  region = RGN_DATA;
            default: region = RGN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cpu_wr && region == RGN_CMD) begin
            cmd_q <= sel_nibble;
        end
    end

    assign data_wr = cpu_wr && (region == RGN_DATA);

endmodule

// File: rtl/cart_bank_store.sv
module cart_bank_store
    import cart_bank_pkg::*;
#(
    parameter int PAT_COUNT = N_PATTERN,
    parameter int PAT_W     = BYTE_BITS,
    parameter int PRG_COUNT = N_PROGRAM,
    parameter int PRG_W     = PROG_BITS,
    parameter int DATA_W    = BYTE_BITS,
    parameter int CMD_W     = SEL_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         data_wr,
    input  logic [CMD_W-1:0]             cmd,
    input  logic [DATA_W-1:0]            wdata,
    output logic [PAT_COUNT*PAT_W-1:0]   pat_banks,
    output logic [PRG_COUNT*PRG_W-1:0]   prg_banks,
    output logic [DATA_W-1:0]            wram_ctl,
    output mirror_e                      mirror
);

    localparam int CMD_WRAM = PAT_COUNT;
    localparam int CMD_PRG0 = PAT_COUNT + 1;
    localparam int CMD_MIRR = CMD_PRG0 + PRG_COUNT;

    for (genvar i = 0; i < PAT_COUNT; i++) begin : g_pat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pat_banks[i*PAT_W +: PAT_W] <= '0;
            end else if (data_wr && cmd == CMD_W'(i)) begin
                pat_banks[i*PAT_W +: PAT_W] <= wdata[PAT_W-1:0];
            end
        end
    end

    for (genvar j = 0; j < PRG_COUNT; j++) begin : g_prg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prg_banks[j*PRG_W +: PRG_W] <= '0;
            end else if (data_wr && cmd == CMD_W'(CMD_PRG0 + j)) begin
                prg_banks[j*PRG_W +: PRG_W] <= wdata[PRG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wram_ctl <= '0;
            mirror   <= MIR_VERTICAL;
        end else if (data_wr) begin
            if (cmd == CMD_W'(CMD_WRAM)) begin
                wram_ctl <= wdata;
            end
            if (cmd == CMD_W'(CMD_MIRR)) begin
                mirror <= mirror_e'(wdata[1:0]);
            end
        end
    end

endmodule

// File: rtl/cart_irq_timer.sv
module cart_irq_timer
    import cart_bank_pkg::*;
#(
    parameter int CNT_W  = TIMER_BITS,
    parameter int DATA_W = BYTE_BITS,
    parameter int CMD_W  = SEL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cpu_ce,
    output logic [CNT_W-1:0]  count_q,
    output logic              run_q,
    output logic              arm_q,
    output logic              irq
);

    localparam int CMD_CTL = (1 << CMD_W) - 3;
    localparam int CMD_LO  = (1 << CMD_W) - 2;
    localparam int CMD_HI  = (1 << CMD_W) - 1;

    logic      ctl_wr, lo_wr, hi_wr, tick, wrap;
    irq_line_e state_q, state_d;

    assign ctl_wr = data_wr && cmd == CMD_W'(CMD_CTL);
    assign lo_wr  = data_wr && cmd == CMD_W'(CMD_LO);
    assign hi_wr  = data_wr && cmd == CMD_W'(CMD_HI);
    assign tick   = cpu_ce && run_q && !(ctl_wr || lo_wr || hi_wr);
    assign wrap   = tick && (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            if (ctl_wr) begin
                run_q <= wdata[DATA_W-1];
                arm_q <= wdata[0];
            end
            if (lo_wr) begin
                count_q[DATA_W-1:0] <= wdata;
            end else if (hi_wr) begin
                count_q[CNT_W-1:DATA_W] <= wdata[CNT_W-DATA_W-1:0];
            end else if (tick) begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:    if (wrap && arm_q) state_d = LINE_PENDING;
            LINE_PENDING: if (ctl_wr)        state_d = LINE_IDLE;
            default:      state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == LINE_PENDING);
    end

endmodule

// File: rtl/cart_bank_regfile.sv
module cart_bank_regfile
    import cart_bank_pkg::*;
#(
    parameter int ADDR_W    = ADDR_BITS,
    parameter int DATA_W    = BYTE_BITS,
    parameter int CMD_W     = SEL_BITS,
    parameter int PAT_COUNT = N_PATTERN,
    parameter int PRG_COUNT = N_PROGRAM,
    parameter int PRG_W     = PROG_BITS,
    parameter int CNT_W     = TIMER_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_wr,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [DATA_W-1:0]             cpu_wdata,
    input  logic                          cpu_ce,
    output logic [PAT_COUNT*DATA_W-1:0]   pat_banks,
    output logic [PRG_COUNT*PRG_W-1:0]    prg_banks,
    output logic [PRG_W-1:0]              wram_bank,
    output logic                          wram_is_ram,
    output logic                          wram_enable,
    output logic [1:0]                    mirror_mode,
    output logic                          irq
);

    logic [CMD_W-1:0]  cmd_q;
    logic              data_wr;
    logic [DATA_W-1:0] wram_ctl;
    mirror_e           mirror;
    logic [CNT_W-1:0]  tmr_count;
    logic              tmr_run, tmr_arm;

    cart_bus_decode #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .region_bits (cpu_addr[ADDR_W-1:ADDR_W-3]),
        .sel_nibble  (cpu_wdata[CMD_W-1:0]),
        .cmd_q       (cmd_q),
        .data_wr     (data_wr)
    );

    cart_bank_store #(
        .PAT_COUNT (PAT_COUNT), .PAT_W (DATA_W), .PRG_COUNT (PRG_COUNT),
        .PRG_W     (PRG_W),     .DATA_W(DATA_W), .CMD_W     (CMD_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .cmd       (cmd_q),
        .wdata     (cpu_wdata),
        .pat_banks (pat_banks),
        .prg_banks (prg_banks),
        .wram_ctl  (wram_ctl),
        .mirror    (mirror)
    );

    cart_irq_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .cmd     (cmd_q),
        .wdata   (cpu_wdata),
        .cpu_ce  (cpu_ce),
        .count_q (tmr_count),
        .run_q   (tmr_run),
        .arm_q   (tmr_arm),
        .irq     (irq)
    );

    assign wram_bank   = wram_ctl[PRG_W-1:0];
    assign wram_is_ram = wram_ctl[DATA_W-2];
    assign wram_enable = wram_ctl[DATA_W-1];
    assign mirror_mode = mirror;

endmodule

// File: rtl/cart_bank_regfile_chk.sv
module cart_bank_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_wr,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_ce,
    input logic [63:0] pat_banks,
    input logic [17:0] prg_banks,
    input logic [1:0]  mirror_mode,
    input logic        irq,
    input logic [3:0]  cmd_q,
    input logic [15:0] tmr_count,
    input logic        tmr_run
);

    logic sel_wr, port_wr, tmr_wr;
    assign sel_wr  = cpu_wr && cpu_addr[15:13] == 3'b100;
    assign port_wr = cpu_wr && cpu_addr[15:13] == 3'b101;
    assign tmr_wr  = port_wr && cmd_q >= 4'd13;

    // R2
    cmd_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> $stable(pat_banks) && $stable(prg_banks) && $stable(mirror_mode));

    // R2
    cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> cmd_q == $past(cpu_wdata[3:0]));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && tmr_run && !tmr_wr) |=> tmr_count == $past(tmr_count) - 16'd1);

    // R9
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ce && !tmr_wr) |=> $stable(tmr_count));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tmr_count) == 16'd0 && $past(cpu_ce)));

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(port_wr && cmd_q == 4'd13)) |=> irq);

    // R11
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && cmd_q == 4'd13) |=> !irq);

endmodule

bind cart_bank_regfile cart_bank_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr      (cpu_wr),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_ce      (cpu_ce),
    .pat_banks   (pat_banks),
    .prg_banks   (prg_banks),
    .mirror_mode (mirror_mode),
    .irq         (irq),
    .cmd_q       (cmd_q),
    .tmr_count   (tmr_count),
    .tmr_run     (tmr_run)
);

// File: tb/cart_bank_regfile_tb.sv
`timescale 1ns/1ps
module cart_bank_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ce = 1'b0;
    logic [63:0] pat_banks;
    logic [17:0] prg_banks;
    logic [5:0]  wram_bank;
    logic        wram_is_ram, wram_enable;
    logic [1:0]  mirror_mode;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cart_bank_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ce(cpu_ce), .pat_banks(pat_banks),
        .prg_banks(prg_banks), .wram_bank(wram_bank), .wram_is_ram(wram_is_ram),
        .wram_enable(wram_enable), .mirror_mode(mirror_mode), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic ce = 1'b0);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_ce = ce;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_ce = 1'b0;
    endtask

    task automatic set_reg(input logic [3:0] c, input logic [7:0] d);
        bus_write(16'h8000, {4'h0, c});
        bus_write(16'hA000, d);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cpu_ce = 1'b1;
            @(negedge clk); cpu_ce = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1", "pattern banks", pat_banks, 64'h0);
        check("R1", "program banks", prg_banks, 64'h0);
        check("R1", "wram flags", {wram_enable, wram_is_ram, wram_bank}, 64'h0);
        check("R1", "mirror vertical", mirror_mode, 64'h0);
        check("R1", "irq low", irq, 64'h0);
    endtask

    task automatic t_pattern();
        logic [63:0] exp = '0;
        for (int i = 0; i < 8; i++) begin
            set_reg(i[3:0], 8'h10 * i[7:0] + 8'h0F - i[7:0]);
            exp[i*8 +: 8] = 8'h10 * i[7:0] + 8'h0F - i[7:0];
        end
        check("R4", "all eight pattern banks", pat_banks, exp);
    endtask

    task automatic t_cmd_port();
        logic [63:0] pat_before = pat_banks;
        bus_write(16'h9ABC, 8'hF3);
        check("R2", "select write leaves banks", pat_banks, pat_before);
        bus_write(16'hBFFF, 8'h77);
        check("R2", "only low nibble selects, bank 3", pat_banks[31:24], 64'h77);
        bus_write(16'hC000, 8'h11);
        bus_write(16'h6000, 8'h22);
        bus_write(16'h2000, 8'h33);
        check("R3", "other regions ignored", pat_banks[31:24], 64'h77);
    endtask

    task automatic t_wram();
        set_reg(4'd8, 8'hC5);
        check("R5", "ram enabled and selected", {wram_enable, wram_is_ram, wram_bank}, {2'b11, 6'h05});
        set_reg(4'd8, 8'h3F);
        check("R5", "rom bank in window", {wram_enable, wram_is_ram, wram_bank}, {2'b00, 6'h3F});
    endtask

    task automatic t_prg();
        set_reg(4'd9, 8'hFF);
        set_reg(4'd10, 8'h12);
        set_reg(4'd11, 8'hEA);
        check("R6", "program banks masked", prg_banks, {6'h2A, 6'h12, 6'h3F});
    endtask

    task automatic t_mirror();
        for (int m = 3; m >= 0; m--) begin
            set_reg(4'd12, 8'hFC | m[7:0]);
            check("R7", "mirror code", mirror_mode, m);
        end
    endtask

    task automatic t_count_basic();
        set_reg(4'd14, 8'h02);
        set_reg(4'd15, 8'h00);
        set_reg(4'd13, 8'h81);
        pulses(2);
        check("R10", "no irq before wrap", irq, 0);
        pulses(1);
        check("R10", "irq after wrap from zero", irq, 1);
        pulses(3);
        check("R11", "irq held while counting on", irq, 1);
        bus_write(16'hA000, 8'h00);
        check("R11", "control write clears irq", irq, 0);
    endtask

    task automatic t_byte_keep();
        set_reg(4'd14, 8'h05);
        set_reg(4'd15, 8'h01);
        set_reg(4'd15, 8'h00);
        set_reg(4'd13, 8'h81);
        pulses(5);
        check("R8", "low byte kept after high write", irq, 0);
        pulses(1);
        check("R8", "fires at kept low byte plus one", irq, 1);
        set_reg(4'd13, 8'h00);
    endtask

    task automatic t_no_run();
        set_reg(4'd14, 8'h00);
        set_reg(4'd15, 8'h00);
        set_reg(4'd13, 8'h01);
        pulses(4);
        check("R9", "no count with run clear", irq, 0);
        bus_write(16'hA000, 8'h81);
        repeat (6) @(negedge clk);
        check("R9", "no count without clock enable", irq, 0);
        pulses(1);
        check("R9", "counter still at zero", irq, 1);
        bus_write(16'hA000, 8'h00);
    endtask

    task automatic t_coincide();
        set_reg(4'd14, 8'h01);
        set_reg(4'd15, 8'h00);
        set_reg(4'd13, 8'h81);
        bus_write(16'hA000, 8'h81, 1'b1);
        pulses(1);
        check("R9", "pulse during control write not counted", irq, 0);
        pulses(1);
        check("R9", "fires on second pulse", irq, 1);
        bus_write(16'hA000, 8'h00);
    endtask

    task automatic t_unarmed();
        set_reg(4'd14, 8'h00);
        set_reg(4'd15, 8'h00);
        set_reg(4'd13, 8'h80);
        pulses(1);
        check("R10", "wrap with arm clear stays low", irq, 0);
        set_reg(4'd14, 8'h00);
        set_reg(4'd15, 8'h00);
        set_reg(4'd13, 8'h81);
        pulses(1);
        check("R10", "armed wrap fires", irq, 1);
    endtask

    task automatic t_timing();
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'h8000; cpu_wdata = 8'h01;
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_wdata = 8'h5A;
        check("R12", "bank unchanged before edge", pat_banks[15:8], 64'h0);
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R12", "bank updated after one edge", pat_banks[15:8], 64'h5A);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_pattern();
        t_cmd_port();
        t_wram();
        t_prg();
        t_mirror();
        t_count_basic();
        t_byte_keep();
        t_no_run();
        t_coincide();
        t_unarmed();
        do_reset();
        t_reset();
        t_timing();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule